// File: doc/BRIEF.md
# Multislope ADC Runup Modulator

This block sequences the integration (runup) phase of a multislope integrating converter. A command word gives the number of integration steps. After accepting it, the block first asks an external residue converter for a pre-conversion sample and waits for that sample to finish. It then drives the three analog switch enables (input connect, positive reference, negative reference) through a repeating step made of a short positive-reference phase, a long phase whose reference polarity follows the comparator, and a short negative-reference phase.

Every step switches the references in the same order, so charge errors at the transitions are identical from step to step. Only the steps whose long phase used the negative reference are counted; the remaining steps follow from the fixed total. When the last step ends, the input switch opens, the negative reference stays on for the following rundown, and the count is presented for one clock.

Top module: `msadc_runup`

## Requirements
- R1: After reset, cmd_ready is 1 and sw_in, sw_pos, sw_neg, pre_req and res_valid are all 0.
- R2: A command is taken on a clock where cmd_valid and cmd_ready are both 1. From the next clock pre_req is 1 and all three switch enables are 0, and this holds for as long as pre_ack is 0; runup starts on the clock after pre_ack is sampled 1.
- R3: A command value N gives exactly N+1 steps, each 2*SHORT_CLKS+LONG_CLKS clocks long, with sw_in at 1 during every clock of every step.
- R4: Within a step, the first SHORT_CLKS clocks enable only the positive reference, the next LONG_CLKS clocks enable one reference chosen by the comparator, and the last SHORT_CLKS clocks enable only the negative reference.
- R5: comp_in passes through a two-flop synchronizer and is sampled once per step, at the last clock of the first short phase; a sampled 1 selects the negative reference for the long phase, a sampled 0 the positive reference.
- R6: sw_pos and sw_neg are never 1 in the same clock.
- R7: On the clock after the last step, res_valid is 1 for exactly one clock and res_count equals the number of steps whose long phase used the negative reference (the complement of a counter that starts at all ones and decrements once per such step).
- R8: In the result clock and in the idle state after it, sw_in and sw_pos are 0 and sw_neg is 1, until the next command is accepted.
- R9: cmd_valid while cmd_ready is 0 is ignored: it changes neither the length nor the result of the running conversion.
- R10: LONG_CLKS below 4, SHORT_CLKS below 1 or fewer than two synchronizer stages are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_steps | input | CNT_W | Step count minus one |
| cmd_ready | output | 1 | Idle, command can be taken |
| pre_req | output | 1 | Pre-conversion residue sample request |
| pre_ack | input | 1 | Residue sample complete |
| comp_in | input | 1 | Asynchronous comparator output |
| sw_in | output | 1 | Input switch enable |
| sw_pos | output | 1 | Positive reference enable |
| sw_neg | output | 1 | Negative reference enable |
| res_valid | output | 1 | Runup count valid (one clock) |
| res_count | output | CNT_W | Number of negative-long-phase steps |

## Verification
Conversions are run with a single step under both comparator levels, which separates the count path from the step-length path, and with all-high, all-low and mixed comparator sequences over longer runs, where a wrong sampling point or inverted polarity shows as a wrong per-step switch pattern or count. A conversion with a delayed acknowledge shows whether the block really stalls before runup, and a command pulsed mid-conversion shows whether a busy block ignores it.

// File: rtl/msr_pkg.sv
package msr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_RUN  = 2'd2,
      ST_DONE = 2'd3
   } msr_state_e;

   typedef enum logic [1:0] {
      SEG_POS  = 2'd0,
      SEG_LONG = 2'd1,
      SEG_NEG  = 2'd2
   } msr_seg_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msr_sync: R10 needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[i] <= 1'b0;
            else if (i == 0) sr[i] <= d;
            else sr[i] <= sr[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/msr_phase.sv
module msr_phase
   import msr_pkg::*;
#(
   parameter int SHORT_CLKS = 2,
   parameter int LONG_CLKS  = 12,
   localparam int STEP_CLKS = 2*SHORT_CLKS + LONG_CLKS,
   localparam int PW        = $clog2(STEP_CLKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [PW-1:0] ph,
   output msr_seg_e      seg,
   output logic          sample_tick,
   output logic          step_end
);
   localparam logic [PW-1:0] PH_SAMPLE = PW'(SHORT_CLKS - 1);
   localparam logic [PW-1:0] PH_LONG   = PW'(SHORT_CLKS);
   localparam logic [PW-1:0] PH_TAIL   = PW'(SHORT_CLKS + LONG_CLKS);
   localparam logic [PW-1:0] PH_LAST   = PW'(STEP_CLKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ph <= '0;
      else if (!run)     ph <= '0;
      else if (step_end) ph <= '0;
      else               ph <= ph + 1'b1;
   end

   always_comb begin
      if (ph < PH_LONG)      seg = SEG_POS;
      else if (ph < PH_TAIL) seg = SEG_LONG;
      else                   seg = SEG_NEG;
   end

   assign sample_tick = run && (ph == PH_SAMPLE);
   assign step_end    = run && (ph == PH_LAST);

   a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ph <= PH_LAST);
   a_r3_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      step_end |=> (ph == '0));
endmodule

// File: rtl/msadc_runup.sv
module msadc_runup
   import msr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SHORT_CLKS  = 2,
   parameter int LONG_CLKS   = 12,
   parameter int SYNC_STAGES = 2,
   localparam int STEP_CLKS  = 2*SHORT_CLKS + LONG_CLKS,
   localparam int PW         = $clog2(STEP_CLKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CNT_W-1:0] cmd_steps,
   output logic             cmd_ready,
   output logic             pre_req,
   input  logic             pre_ack,
   input  logic             comp_in,
   output logic             sw_in,
   output logic             sw_pos,
   output logic             sw_neg,
   output logic             res_valid,
   output logic [CNT_W-1:0] res_count
);
   generate
      if (LONG_CLKS < 4) begin : g_bad_long
         $error("msadc_runup: R10 long phase must be at least four clocks");
      end
      if (SHORT_CLKS < 1) begin : g_bad_short
         $error("msadc_runup: R10 short phase must be at least one clock");
      end
   endgenerate

   msr_state_e       state;
   logic [CNT_W-1:0] steps_left;
   logic [CNT_W-1:0] down_cnt;
   logic             long_neg;
   logic             idle_neg;
   logic             comp_s;
   logic [PW-1:0]    ph;
   msr_seg_e         seg;
   logic             sample_tick;
   logic             step_end;
   logic             running;

   assign running = (state == ST_RUN);

   msr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (comp_in),
      .q     (comp_s)
   );

   msr_phase #(.SHORT_CLKS(SHORT_CLKS), .LONG_CLKS(LONG_CLKS)) u_phase (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (running),
      .ph          (ph),
      .seg         (seg),
      .sample_tick (sample_tick),
      .step_end    (step_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         steps_left <= '0;
         down_cnt   <= '1;
         long_neg   <= 1'b0;
         idle_neg   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               state      <= ST_PRE;
               steps_left <= cmd_steps;
               idle_neg   <= 1'b0;
            end
            ST_PRE: if (pre_ack) begin
               state    <= ST_RUN;
               down_cnt <= '1;
            end
            ST_RUN: begin
               if (sample_tick) begin
                  long_neg <= comp_s;
                  if (comp_s) down_cnt <= down_cnt - 1'b1;
               end
               if (step_end) begin
                  if (steps_left == '0) state <= ST_DONE;
                  else steps_left <= steps_left - 1'b1;
               end
            end
            ST_DONE: begin
               state    <= ST_IDLE;
               idle_neg <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state == ST_IDLE);
   assign pre_req   = (state == ST_PRE);
   assign sw_in     = running;
   assign sw_pos    = running && ((seg == SEG_POS) || (seg == SEG_LONG && !long_neg));
   assign sw_neg    = (running && ((seg == SEG_NEG) || (seg == SEG_LONG && long_neg)))
                    || (state == ST_DONE) || ((state == ST_IDLE) && idle_neg);
   assign res_valid = (state == ST_DONE);
   assign res_count = ~down_cnt;

   a_r6_refs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_pos && sw_neg));
   a_r2_stall_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req && !pre_ack) |=> (pre_req && !sw_in && !sw_pos && !sw_neg));
   a_r2_start_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req && pre_ack) |=> sw_in);
   a_r7_result_single: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   a_r8_neg_held: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (sw_neg && !sw_in && !sw_pos));
   a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_in && cmd_valid) |=> !cmd_ready && !pre_req);
endmodule

// File: tb/msadc_runup_test.sv
module msadc_runup_test;
   localparam int CNT_W = 16;
   localparam int SHORT = 2;
   localparam int LONG  = 12;
   localparam int STEP  = 2*SHORT + LONG;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [CNT_W-1:0] cmd_steps = '0;
   logic             cmd_ready;
   logic             pre_req;
   logic             pre_ack = 1'b0;
   logic             comp_in = 1'b0;
   logic             sw_in, sw_pos, sw_neg;
   logic             res_valid;
   logic [CNT_W-1:0] res_count;

   int checks = 0;
   int fails  = 0;
   int exp_cnt_q[$];
   int exp_cyc_q[$];
   logic [63:0] pat = '0;
   int results_seen = 0;
   int t = 0;
   logic step_err = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   msadc_runup #(.CNT_W(CNT_W), .SHORT_CLKS(SHORT), .LONG_CLKS(LONG)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_steps(cmd_steps),
      .cmd_ready(cmd_ready), .pre_req(pre_req), .pre_ack(pre_ack),
      .comp_in(comp_in), .sw_in(sw_in), .sw_pos(sw_pos), .sw_neg(sw_neg),
      .res_valid(res_valid), .res_count(res_count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: per-step switch pattern, comparator stimulus, scoreboard pop
   always @(negedge clk) begin
      if (rst_n && sw_in) begin
         int ph, st;
         logic ep, en;
         ph = t % STEP;
         st = t / STEP;
         if (ph < SHORT) begin ep = 1'b1; en = 1'b0; end
         else if (ph < SHORT + LONG) begin en = pat[st]; ep = !pat[st]; end
         else begin ep = 1'b0; en = 1'b1; end
         if (sw_pos !== ep || sw_neg !== en) step_err = 1'b1;
         if (ph == SHORT + LONG/2 && st < 63) comp_in = pat[st+1];
         if (ph == STEP - 1) begin
            check(!step_err, "R4/R5/R6 step pattern", {sw_pos, sw_neg}, {ep, en});
            step_err = 1'b0;
         end
         t++;
      end else if (rst_n && res_valid) begin
         int ec, ey;
         if (exp_cnt_q.size() == 0) begin
            check(1'b0, "R7 unexpected result", int'(res_count), -1);
         end else begin
            ec = exp_cnt_q.pop_front();
            ey = exp_cyc_q.pop_front();
            check(int'(res_count) == ec, "R7 runup count", int'(res_count), ec);
            check(t == ey, "R3/R9 runup length", t, ey);
            check(sw_neg && !sw_in && !sw_pos, "R8 result-clock switches",
                  {sw_in, sw_pos, sw_neg}, 1);
         end
         t = 0;
         results_seen++;
      end
   end

   task automatic run_conv(input int n, input logic [63:0] p, input int ack_wait, input bit poke);
      int ec, seen;
      ec = 0;
      for (int i = 0; i <= n; i++) ec += int'(p[i]);
      while (!cmd_ready) @(negedge clk);
      pat = p;
      comp_in = p[0];
      cmd_steps = CNT_W'(n);
      cmd_valid = 1'b1;
      exp_cnt_q.push_back(ec);
      exp_cyc_q.push_back((n + 1) * STEP);
      seen = results_seen;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(pre_req && !sw_in && !sw_pos && !sw_neg, "R2 pre-sample request",
            {pre_req, sw_in, sw_pos, sw_neg}, 8);
      for (int i = 0; i < ack_wait; i++) @(negedge clk);
      check(pre_req && !sw_in, "R2 stall without ack", {pre_req, sw_in}, 2);
      pre_ack = 1'b1;
      @(negedge clk);
      pre_ack = 1'b0;
      check(sw_in && !pre_req, "R2 runup start after ack", {pre_req, sw_in}, 1);
      if (poke) begin
         repeat (5) @(negedge clk);
         check(!cmd_ready, "R9 busy while running", int'(cmd_ready), 0);
         cmd_steps = CNT_W'(3);
         cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (results_seen == seen) @(negedge clk);
      @(negedge clk);
      check(cmd_ready && sw_neg && !sw_in && !sw_pos && !pre_req, "R8 idle holds negative ref",
            {cmd_ready, sw_in, sw_pos, sw_neg}, 9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cmd_ready && !sw_in && !sw_pos && !sw_neg && !pre_req && !res_valid,
            "R1 reset state", {cmd_ready, sw_in, sw_pos, sw_neg, pre_req, res_valid}, 32);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready && !sw_neg && !res_valid, "R1 after reset release",
            {cmd_ready, sw_neg, res_valid}, 4);
      run_conv(0, 64'h1, 0, 1'b0);                       // single step, high
      run_conv(0, 64'h0, 2, 1'b0);                       // single step, low
      run_conv(7, 64'hAA, 1, 1'b0);                      // alternating
      run_conv(15, 64'hFFFF, 0, 1'b0);                   // all high
      run_conv(9, 64'h0, 4, 1'b0);                       // all low
      run_conv(31, 64'h9C3A_56E1, 0, 1'b1);              // mixed, busy command poke
      run_conv(5, 64'h21, 3, 1'b0);
      finished = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!finished && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!finished) check(1'b0, "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule